// File: doc/BRIEF.md
# Memory Test Driver

This block drives a fixed battery of memory tests through a plain memory-controller request port. It writes patterns, reads them back and compares every byte lane against the value it expects. Each read's expected word goes into a small queue when the read is accepted. Returned data arrives with a valid strobe and any latency, in request order, and is matched against the head of that queue. Write data is computed from the address and a seed chosen for each test. The block therefore keeps no copy of the memory contents.

The suite starts on its own when reset is released and runs seven tests in a fixed order:

- **Sequential fill.** Every location is written and then read back.
- **Partial coverage.** Only the even locations are rewritten, and all locations are read back.
- **Byte-enable check.** A background pattern is written, then a second pattern is written with alternate byte lanes disabled, and the result is read back.
- **Walking-one address check.** Address 0 and each one-hot address are written and read back.
- **Low-power power-down hold.** The memory is held in power-down for a programmed number of cycles.
- **Low-power self-refresh hold.** The memory is held in self-refresh for a programmed number of cycles.
- **Back-to-back access.** Each location is written and immediately read back.

The two low-power holds exist only when the build parameter `LP_EN` is set.

Four outputs report progress and results:

- `pass_all` is a sticky pass flag for the whole run.
- `pass_lane` holds one pass flag per byte lane; each flag reflects that lane's most recent compare.
- `test_status` is a one-hot code naming the test that is running.
- `suite_done` pulses once when the suite ends.

Top module: `memtest_driver`

## Requirements
- R1: `pass_all` is 1 during and after reset. It drops to 0 in the cycle after a returned read has any byte differing from its expected value. It then stays 0 until the next reset.
- R2: Each `pass_lane[b]` is 1 after reset. In the cycle after a returned read, `pass_lane[b]` takes 1 if lane b (bits 8b+7..8b) matched and 0 if it did not. In cycles with no returned read it holds its value, so a lane that failed recovers on its next correct compare.
- R3: `test_status` is 7 bits and at most one of them is set. Bit 0 is the sequential fill, bit 1 the partial-coverage test, bit 2 the byte-enable test, bit 3 the walking-one address test, bit 4 the power-down hold, bit 5 the self-refresh hold and bit 6 the back-to-back test. Tests run in ascending bit order, and the code is 0 once the suite has ended.
- R4: `suite_done` is high for exactly one cycle after the last test ends, and it pulses only once per reset.
- R5: In the power-down test `pd_req` is high for exactly `hold_cycles` consecutive cycles, with 0 treated as 1, and only while `test_status` is 7'b0010000. `sr_req` behaves the same way in the self-refresh test, with status 7'b0100000.
- R6: With `LP_EN` = 0 the two low-power tests are skipped. Status bits 4 and 5 never assert, and `pd_req` and `sr_req` stay 0.
- R7: A request is accepted in a cycle where both `req_valid` and `req_ready` are high. While a request waits for `req_ready`, its address and direction stay stable. A test ends only after all of its reads have returned and been compared, whatever the read latency.
- R8: The partial-coverage test writes only the even addresses. The odd addresses must still hold the sequential-fill data when they are read back.
- R9: In the byte-enable test, each location gets a full write and then a rewrite with `req_be` = 4'b0101, where bit b enables lane b. The disabled lanes must still hold the background value, so a faithful memory passes.
- R10: The walking-one address test writes and reads address 0 and every address 2^k for k < `ADDR_W`, which is {0,1,2,4,8} for the default width.
- R11: With the default 16-word space, one suite issues 77 writes and 69 reads. Against a faithful memory it ends with `pass_all` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all ports are synchronous to it |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| hold_cycles | input | HOLD_W | Length of each low-power hold in cycles |
| req_ready | input | 1 | Controller accepts the current request |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 8*BYTES | Returned read data |
| req_valid | output | 1 | Request present |
| req_write | output | 1 | 1 for write, 0 for read |
| req_addr | output | ADDR_W | Word address |
| req_wdata | output | 8*BYTES | Write data |
| req_be | output | BYTES | Byte enables for writes |
| pd_req | output | 1 | Power-down request |
| sr_req | output | 1 | Self-refresh request |
| pass_all | output | 1 | Sticky overall pass flag |
| pass_lane | output | BYTES | Per-lane pass flags |
| test_status | output | 7 | One-hot code of the running test |
| suite_done | output | 1 | One-cycle end-of-suite pulse |

## Verification
The driver is run against a behavioural memory whose ready line drops every fifth cycle and whose read latency varies between one and three cycles. The fault patterns are:

- A clean memory shows that masked and partial writes leave exactly the data the checks expect.
- A single one-shot byte flip on the first read of a chosen address and lane shows that the sticky flag and the per-lane flag behave differently: the overall flag stays low while only the affected lane falls and recovers.
- Placing that fault at address 0 and at the last address exercises the first and last compares of the fill test.

Hold counts of 0, 1 and larger values separate the minimum hold from ordinary holds. A second instance built without the low-power tests shows the skipped status bits.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_DRAIN,
        ST_HOLD,
        ST_FIN,
        ST_IDLE
    } seq_st_e;

    typedef enum logic [1:0] {
        K_WR,
        K_WR_EVEN,
        K_RD,
        K_WRRD
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic       walk;
        logic [7:0] seed;
        logic       masked;
        logic       last;
    } pass_t;

    localparam int unsigned NUM_TESTS = 7;

    localparam logic [7:0] SEED_FILL = 8'h5A;
    localparam logic [7:0] SEED_PART = 8'hC3;
    localparam logic [7:0] SEED_BG   = 8'hF0;
    localparam logic [7:0] SEED_MSK  = 8'h0F;
    localparam logic [7:0] SEED_WALK = 8'h96;
    localparam logic [7:0] SEED_B2B  = 8'h3C;

    function automatic pass_t pass_info(input logic [2:0] t, input logic [1:0] p);
        pass_t r;
        r = '{kind: K_RD, walk: 1'b0, seed: SEED_FILL, masked: 1'b0, last: 1'b1};
        case (t)
            3'd0: begin
                if (p == 2'd0) begin
                    r.kind = K_WR;
                    r.last = 1'b0;
                end
            end
            3'd1: begin
                if (p == 2'd0) begin
                    r.kind = K_WR_EVEN;
                    r.seed = SEED_PART;
                    r.last = 1'b0;
                end
            end
            3'd2: begin
                if (p == 2'd0) begin
                    r.kind = K_WR;
                    r.seed = SEED_BG;
                    r.last = 1'b0;
                end else if (p == 2'd1) begin
                    r.kind   = K_WR;
                    r.seed   = SEED_MSK;
                    r.masked = 1'b1;
                    r.last   = 1'b0;
                end
            end
            3'd3: begin
                r.walk = 1'b1;
                r.seed = SEED_WALK;
                if (p == 2'd0) begin
                    r.kind = K_WR;
                    r.last = 1'b0;
                end
            end
            3'd6: begin
                r.kind = K_WRRD;
                r.seed = SEED_B2B;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mtd_fifo.sv
module mtd_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [PW:0]   cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (push) d.wp = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (pop)  d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q.wp] <= din;
    end

    assign dout  = mem[q.rp];
    assign full  = (q.cnt == (PW+1)'(DEPTH));
    assign empty = (q.cnt == '0);
endmodule

// File: rtl/mtd_lane_cmp.sv
module mtd_lane_cmp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chk,
    input  logic [7:0] got,
    input  logic [7:0] want,
    output logic       ok
);
    logic ok_d, ok_q;

    always_comb begin
        ok_d = ok_q;
        if (chk) ok_d = (got == want);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok_q <= 1'b1;
        else        ok_q <= ok_d;
    end

    assign ok = ok_q;
endmodule

// File: rtl/mtd_seq.sv
module mtd_seq
    import mtd_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BYTES  = 4,
    parameter int unsigned HOLD_W = 16,
    parameter bit          LP_EN  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HOLD_W-1:0]   hold_cycles,
    input  logic                req_ready,
    input  logic                fifo_full,
    input  logic                fifo_empty,
    output logic                req_valid,
    output logic                req_write,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [8*BYTES-1:0]  req_wdata,
    output logic [BYTES-1:0]    req_be,
    output logic                exp_push,
    output logic [8*BYTES-1:0]  exp_data,
    output logic                pd_req,
    output logic                sr_req,
    output logic [NUM_TESTS-1:0] test_status,
    output logic                suite_done
);
    localparam int unsigned DW    = 8 * BYTES;
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned CNT_W = ADDR_W + 1;

    typedef struct packed {
        seq_st_e           st;
        logic [2:0]        test;
        logic [1:0]        pass;
        logic [CNT_W-1:0]  cnt;
        logic              sub;
        logic [HOLD_W-1:0] hold;
    } seq_t;

    localparam seq_t RESET_Q = '{st: ST_RUN, test: 3'd0, pass: 2'd0, cnt: '0, sub: 1'b0, hold: '0};

    function automatic logic [DW-1:0] pat(input logic [ADDR_W-1:0] a, input logic [7:0] s);
        logic [DW-1:0] r;
        for (int b = 0; b < int'(BYTES); b++) r[8*b +: 8] = 8'(a) ^ s ^ 8'(37 * b);
        return r;
    endfunction

    function automatic logic [BYTES-1:0] even_be();
        logic [BYTES-1:0] r;
        for (int b = 0; b < int'(BYTES); b++) r[b] = ((b % 2) == 0);
        return r;
    endfunction

    function automatic logic [DW-1:0] expect_of(input logic [2:0] t, input logic [ADDR_W-1:0] a);
        logic [DW-1:0] r, bg, mk;
        case (t)
            3'd1:    r = a[0] ? pat(a, SEED_FILL) : pat(a, SEED_PART);
            3'd2: begin
                bg = pat(a, SEED_BG);
                mk = pat(a, SEED_MSK);
                for (int b = 0; b < int'(BYTES); b++)
                    r[8*b +: 8] = ((b % 2) == 0) ? mk[8*b +: 8] : bg[8*b +: 8];
            end
            3'd3:    r = pat(a, SEED_WALK);
            3'd6:    r = pat(a, SEED_B2B);
            default: r = pat(a, SEED_FILL);
        endcase
        return r;
    endfunction

    seq_t q, d;
    pass_t pi;
    logic [ADDR_W-1:0] addr;
    logic last_cnt, step;
    logic [2:0] nxt;

    always_comb begin
        d    = q;
        pi   = pass_info(q.test, q.pass);
        step = 1'b0;
        nxt  = q.test + 3'd1;
        if (!LP_EN && nxt == 3'd4) nxt = 3'd6;

        if (pi.walk) begin
            addr     = (q.cnt == '0) ? '0 : (ADDR_W'(1) << (q.cnt - CNT_W'(1)));
            last_cnt = (q.cnt == CNT_W'(ADDR_W));
        end else begin
            addr     = q.cnt[ADDR_W-1:0];
            last_cnt = (q.cnt == CNT_W'(DEPTH - 1));
        end

        req_valid   = 1'b0;
        req_write   = 1'b0;
        req_addr    = addr;
        req_wdata   = pat(addr, pi.seed);
        req_be      = pi.masked ? even_be() : '1;
        exp_push    = 1'b0;
        exp_data    = expect_of(q.test, addr);
        pd_req      = 1'b0;
        sr_req      = 1'b0;
        suite_done  = 1'b0;
        test_status = '0;

        case (q.st)
            ST_RUN: begin
                case (pi.kind)
                    K_WR: begin
                        req_valid = 1'b1;
                        req_write = 1'b1;
                        step      = req_ready;
                    end
                    K_WR_EVEN: begin
                        if (addr[0]) begin
                            step = 1'b1;
                        end else begin
                            req_valid = 1'b1;
                            req_write = 1'b1;
                            step      = req_ready;
                        end
                    end
                    K_RD: begin
                        req_valid = !fifo_full;
                        exp_push  = req_valid && req_ready;
                        step      = exp_push;
                    end
                    default: begin
                        if (!q.sub) begin
                            req_valid = 1'b1;
                            req_write = 1'b1;
                            if (req_ready) d.sub = 1'b1;
                        end else begin
                            req_valid = !fifo_full;
                            exp_push  = req_valid && req_ready;
                            if (exp_push) begin
                                d.sub = 1'b0;
                                step  = 1'b1;
                            end
                        end
                    end
                endcase
                if (step) begin
                    if (last_cnt) begin
                        d.cnt = '0;
                        if (pi.last) begin
                            d.st   = ST_DRAIN;
                            d.pass = 2'd0;
                        end else begin
                            d.pass = q.pass + 2'd1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (fifo_empty) begin
                    if (q.test == 3'd6) begin
                        d.st = ST_FIN;
                    end else begin
                        d.test = nxt;
                        d.hold = '0;
                        d.st   = (nxt == 3'd4 || nxt == 3'd5) ? ST_HOLD : ST_RUN;
                    end
                end
            end
            ST_HOLD: begin
                pd_req = (q.test == 3'd4);
                sr_req = (q.test == 3'd5);
                if (({1'b0, q.hold} + 1'b1) >= {1'b0, hold_cycles}) d.st = ST_DRAIN;
                else                                                 d.hold = q.hold + 1'b1;
            end
            ST_FIN: begin
                suite_done = 1'b1;
                d.st       = ST_IDLE;
            end
            default: ;
        endcase

        if (q.st == ST_RUN || q.st == ST_DRAIN || q.st == ST_HOLD)
            test_status = NUM_TESTS'(1) << q.test;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_Q;
        else        q <= d;
    end
endmodule

// File: rtl/memtest_driver.sv
module memtest_driver
    import mtd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned BYTES      = 4,
    parameter int unsigned HOLD_W     = 16,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter bit          LP_EN      = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HOLD_W-1:0]    hold_cycles,
    input  logic                 req_ready,
    input  logic                 rd_valid,
    input  logic [8*BYTES-1:0]   rd_data,
    output logic                 req_valid,
    output logic                 req_write,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [8*BYTES-1:0]   req_wdata,
    output logic [BYTES-1:0]     req_be,
    output logic                 pd_req,
    output logic                 sr_req,
    output logic                 pass_all,
    output logic [BYTES-1:0]     pass_lane,
    output logic [6:0]           test_status,
    output logic                 suite_done
);
    localparam int unsigned DW = 8 * BYTES;

    logic          exp_push, fifo_full, fifo_empty, chk;
    logic [DW-1:0] exp_data, exp_front;
    logic          pass_d, pass_q;

    mtd_seq #(
        .ADDR_W (ADDR_W),
        .BYTES  (BYTES),
        .HOLD_W (HOLD_W),
        .LP_EN  (LP_EN)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_cycles (hold_cycles),
        .req_ready   (req_ready),
        .fifo_full   (fifo_full),
        .fifo_empty  (fifo_empty),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .exp_push    (exp_push),
        .exp_data    (exp_data),
        .pd_req      (pd_req),
        .sr_req      (sr_req),
        .test_status (test_status),
        .suite_done  (suite_done)
    );

    mtd_fifo #(
        .W     (DW),
        .DEPTH (FIFO_DEPTH)
    ) u_exp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (exp_push),
        .din   (exp_data),
        .pop   (chk),
        .dout  (exp_front),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    assign chk = rd_valid && !fifo_empty;

    for (genvar b = 0; b < int'(BYTES); b++) begin : g_lane
        mtd_lane_cmp u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .chk   (chk),
            .got   (rd_data[8*b +: 8]),
            .want  (exp_front[8*b +: 8]),
            .ok    (pass_lane[b])
        );
    end

    always_comb begin
        pass_d = pass_q;
        if (chk && (rd_data != exp_front)) pass_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pass_q <= 1'b1;
        else        pass_q <= pass_d;
    end

    assign pass_all = pass_q;
endmodule

// File: rtl/memtest_driver_chk.sv
module memtest_driver_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BYTES  = 4,
    parameter bit          LP_EN  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              pd_req,
    input logic              sr_req,
    input logic              pass_all,
    input logic [BYTES-1:0]  pass_lane,
    input logic [6:0]        test_status,
    input logic              suite_done
);
    // R1
    pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_all |=> !pass_all);

    // R1
    pass_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pass_all) |-> $past(rd_valid));

    // R2
    lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> $stable(pass_lane));

    // R3
    status_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(test_status));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suite_done |=> !suite_done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suite_done |-> (test_status == 7'd0));

    // R5
    pd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |-> (test_status == 7'b0010000));

    // R5
    sr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_req |-> (test_status == 7'b0100000));

    // R6
    lp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !LP_EN |-> (test_status[5:4] == 2'b00 && !pd_req && !sr_req));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)));
endmodule

bind memtest_driver memtest_driver_chk #(
    .ADDR_W (ADDR_W),
    .BYTES  (BYTES),
    .LP_EN  (LP_EN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .pd_req      (pd_req),
    .sr_req      (sr_req),
    .pass_all    (pass_all),
    .pass_lane   (pass_lane),
    .test_status (test_status),
    .suite_done  (suite_done)
);

// File: tb/sim_memtest_driver.sv
`timescale 1ns/1ps

module sim_mem #(
    parameter int AW = 4,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [8*NB-1:0] wdata,
    input  logic [NB-1:0]   be,
    input  logic            fault_en,
    input  logic [AW-1:0]   fault_addr,
    input  logic [1:0]      fault_lane,
    output logic            req_ready,
    output logic            rd_valid,
    output logic [8*NB-1:0] rd_data
);
    logic [8*NB-1:0] mem [0:(1<<AW)-1];
    logic [8*NB-1:0] dq [$];
    int              dueq [$];
    int              cyc, nrd, last_due, due;
    bit              used;
    logic [8*NB-1:0] rdv;

    assign req_ready = (cyc % 5) != 4;

    always @(posedge clk) begin
        if (!rst_n) begin
            dq.delete();
            dueq.delete();
            cyc      <= 0;
            nrd      = 0;
            last_due = 0;
            used     = 0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (req_valid && req_ready) begin
                if (req_write) begin
                    for (int b = 0; b < NB; b++)
                        if (be[b]) mem[req_addr][8*b +: 8] = wdata[8*b +: 8];
                end else begin
                    rdv = mem[req_addr];
                    if (fault_en && !used && req_addr == fault_addr) begin
                        rdv[8*fault_lane +: 8] = rdv[8*fault_lane +: 8] ^ 8'h81;
                        used = 1;
                    end
                    due = cyc + 1 + (nrd % 3);
                    if (due <= last_due) due = last_due + 1;
                    last_due = due;
                    nrd++;
                    dq.push_back(rdv);
                    dueq.push_back(due);
                end
            end
            rd_valid <= 1'b0;
            if (dueq.size() > 0 && dueq[0] <= cyc) begin
                rd_valid <= 1'b1;
                rd_data  <= dq.pop_front();
                void'(dueq.pop_front());
            end
            cyc <= cyc + 1;
        end
    end
endmodule

module sim_obs (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] status,
    input logic       pd,
    input logic       sr,
    input logic       done,
    input logic       pass_all,
    input logic [3:0] pass_lane,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [3:0] addr,
    input logic [3:0] be
);
    logic [6:0]  seq [0:15];
    int          nseq, pd_n, sr_n, win_bad, done_n, hot_bad, after_bad, wr_n, rd_n, part_n;
    logic [6:0]  prev;
    logic [15:0] walk_map, part_map;
    logic [3:0]  lane_low;
    bit          all_low, finished;

    always @(negedge clk) begin
        if (!rst_n) begin
            nseq = 0; pd_n = 0; sr_n = 0; win_bad = 0; done_n = 0; hot_bad = 0;
            after_bad = 0; wr_n = 0; rd_n = 0; part_n = 0; prev = '0;
            walk_map = '0; part_map = '0; lane_low = '0; all_low = 0; finished = 0;
        end else begin
            if (!$onehot0(status)) hot_bad++;
            if (status != 0 && status != prev) begin
                if (nseq < 16) seq[nseq] = status;
                nseq++;
            end
            prev = status;
            if (pd) begin pd_n++; if (status != 7'h10) win_bad++; end
            if (sr) begin sr_n++; if (status != 7'h20) win_bad++; end
            if ((done || finished) && status != 0) after_bad++;
            if (done) begin done_n++; finished = 1; end
            if (req_valid && req_ready) begin
                if (req_write) begin
                    wr_n++;
                    if (be == 4'b0101) part_n++;
                    if (status == 7'h08) walk_map[addr] = 1'b1;
                    if (status == 7'h02) part_map[addr] = 1'b1;
                end else begin
                    rd_n++;
                end
            end
            lane_low = lane_low | ~pass_lane;
            if (!pass_all) all_low = 1;
        end
    end
endmodule

module sim_memtest_driver;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic [15:0] hold;
    logic        fen;
    logic [3:0]  faddr;
    logic [1:0]  flane;

    logic        rv0, rw0, rdy0, rdv0, pd0, sr0, pa0, dn0;
    logic [3:0]  ra0, be0, pl0;
    logic [31:0] wd0, rd0;
    logic [6:0]  st0;
    logic        rv1, rw1, rdy1, rdv1, pd1, sr1, pa1, dn1;
    logic [3:0]  ra1, be1, pl1;
    logic [31:0] wd1, rd1;
    logic [6:0]  st1;

    memtest_driver #(.LP_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .hold_cycles(hold), .req_ready(rdy0), .rd_valid(rdv0),
        .rd_data(rd0), .req_valid(rv0), .req_write(rw0), .req_addr(ra0), .req_wdata(wd0),
        .req_be(be0), .pd_req(pd0), .sr_req(sr0), .pass_all(pa0), .pass_lane(pl0),
        .test_status(st0), .suite_done(dn0));

    memtest_driver #(.LP_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .hold_cycles(hold), .req_ready(rdy1), .rd_valid(rdv1),
        .rd_data(rd1), .req_valid(rv1), .req_write(rw1), .req_addr(ra1), .req_wdata(wd1),
        .req_be(be1), .pd_req(pd1), .sr_req(sr1), .pass_all(pa1), .pass_lane(pl1),
        .test_status(st1), .suite_done(dn1));

    sim_mem m0 (.clk(clk), .rst_n(rst_n), .req_valid(rv0), .req_write(rw0), .req_addr(ra0),
        .wdata(wd0), .be(be0), .fault_en(fen), .fault_addr(faddr), .fault_lane(flane),
        .req_ready(rdy0), .rd_valid(rdv0), .rd_data(rd0));
    sim_mem m1 (.clk(clk), .rst_n(rst_n), .req_valid(rv1), .req_write(rw1), .req_addr(ra1),
        .wdata(wd1), .be(be1), .fault_en(fen), .fault_addr(faddr), .fault_lane(flane),
        .req_ready(rdy1), .rd_valid(rdv1), .rd_data(rd1));

    sim_obs o0 (.clk(clk), .rst_n(rst_n), .status(st0), .pd(pd0), .sr(sr0), .done(dn0),
        .pass_all(pa0), .pass_lane(pl0), .req_valid(rv0), .req_ready(rdy0), .req_write(rw0),
        .addr(ra0), .be(be0));
    sim_obs o1 (.clk(clk), .rst_n(rst_n), .status(st1), .pd(pd1), .sr(sr1), .done(dn1),
        .pass_all(pa1), .pass_lane(pl1), .req_valid(rv1), .req_ready(rdy1), .req_write(rw1),
        .addr(ra1), .be(be1));

    typedef struct packed {
        logic [15:0] hold;
        logic        fen;
        logic [3:0]  faddr;
        logic [1:0]  flane;
        logic        pass;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{16'd3,  1'b0, 4'd0,  2'd0, 1'b1},
        '{16'd1,  1'b1, 4'd5,  2'd2, 1'b0},
        '{16'd7,  1'b1, 4'd0,  2'd0, 1'b0},
        '{16'd2,  1'b1, 4'd15, 2'd3, 1'b0},
        '{16'd0,  1'b0, 4'd0,  2'd0, 1'b1},
        '{16'd12, 1'b1, 4'd9,  2'd1, 1'b0}
    };

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        hold  = '0;
        fen   = 1'b0;
        faddr = '0;
        flane = '0;
        for (int v = 0; v < NVEC; v++) begin
            int t;
            int eh;
            @(negedge clk);
            rst_n = 1'b0;
            hold  = VEC[v].hold;
            fen   = VEC[v].fen;
            faddr = VEC[v].faddr;
            flane = VEC[v].flane;
            repeat (3) @(negedge clk);
            // reset state, including recovery of a sticky failure from the prior run
            check("R1", "pass_all in reset", pa0, 1);
            check("R2", "pass_lane in reset", pl0, 4'hF);
            check("R4", "done in reset", dn0, 0);
            check("R5", "low-power req in reset", {pd0, sr0}, 0);
            check("R3", "status in reset", st0, 7'h01);
            rst_n = 1'b1;
            t = 0;
            while (!(o0.finished && o1.finished) && t < 6000) begin
                @(negedge clk);
                t++;
            end
            check("R4", "suite finished", (o0.finished && o1.finished), 1);
            repeat (12) @(negedge clk);
            eh = (VEC[v].hold == 0) ? 1 : int'(VEC[v].hold);

            // R3 order with low-power tests present
            check("R3", "test count", o0.nseq, 7);
            for (int i = 0; i < 7; i++) check("R3", "test order", o0.seq[i], 1 << i);
            check("R3", "one-hot violations", o0.hot_bad, 0);
            check("R4", "done pulses", o0.done_n, 1);
            check("R4", "status after done", o0.after_bad, 0);
            check("R5", "pd cycles", o0.pd_n, eh);
            check("R5", "sr cycles", o0.sr_n, eh);
            check("R5", "req outside its test", o0.win_bad, 0);
            check("R1", "final pass_all", pa0, VEC[v].pass);
            check("R1", "pass_all ever low", o0.all_low, !VEC[v].pass);
            check("R2", "lanes that fell", o0.lane_low, VEC[v].fen ? (4'b1 << VEC[v].flane) : 4'b0);
            check("R2", "lanes recovered", pl0, 4'hF);
            check("R11", "writes", o0.wr_n, 77);
            check("R11", "reads", o0.rd_n, 69);
            check("R9", "masked rewrites", o0.part_n, 16);
            check("R10", "walk addresses", o0.walk_map, 16'h0117);
            check("R8", "partial addresses", o0.part_map, 16'h5555);
            check("R7", "clean compare despite latency", o0.all_low, VEC[v].fen);

            // R6 build without low-power tests
            check("R6", "test count", o1.nseq, 5);
            check("R6", "order 0", o1.seq[0], 7'h01);
            check("R6", "order 3", o1.seq[3], 7'h08);
            check("R6", "order 4", o1.seq[4], 7'h40);
            check("R6", "low-power reqs", o1.pd_n + o1.sr_n, 0);
            check("R6", "pass_all", pa1, VEC[v].pass);
            check("R6", "done pulses", o1.done_n, 1);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule